// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

A 32-pin general-purpose I/O port controlled through six word-wide registers on a simple read/write strobe. Each pin is an input or an output, and an output pin is push-pull or open-drain. The port drives an output value and an output enable for each pad and samples every pad input through a two-flop synchronizer. Reads are combinational from the current address. A write is taken on the clock edge where the request strobe and the write enable are both high.

Pin transitions are captured in sticky event bits. A pin can count only falling edges, or both rising and falling edges. Software clears an event by writing a 1 to its bit. A single interrupt line stays high while any event bit whose mask bit is 1 is pending. Register bit numbering runs opposite to pin numbering. A build parameter selects a variant in which data-register reads return zero for pins configured as outputs.

Top module: `edge_gpio_port`

## Requirements
- R1: Out of reset every register reads 0, every output enable is 0 and the interrupt line is low.
- R2: Byte offsets select the registers as follows: 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event, 0x10 mask, 0x14 edge-select. Offsets 0x18 and 0x1C read 0, and writes to them change no register.
- R3: Pin n corresponds to register bit 31−n in every register, so pin 0 is bit 31.
- R4: A direction bit of 1 makes its pin an output and a direction bit of 0 makes it an input. A push-pull output pin (open-drain bit 0) has its enable high and drives its data bit. An input pin has its enable low.
- R5: For an output pin whose open-drain bit is 1, the pad value is 0, and the enable is high exactly when the data bit is 0.
- R6: In the default build, a data-register read returns the data latch for output pins. For input pins it returns the pad level synchronized through two flops, so a pad change appears in a read two clock edges later.
- R7: With RD_OUT_ZERO set, a data-register read returns 0 for output pins and the synchronized pad level for input pins.
- R8: An edge-select bit of 1 records only falling edges on its pin, and 0 records both rising and falling edges. The event bit is set on the third clock edge after the pad changes.
- R9: Writing 1 to an event bit clears it. Writing 0 to an event bit leaves it unchanged.
- R10: When a qualifying edge and a clearing write reach the same event bit on the same clock edge, the bit stays set.
- R11: The interrupt line is high exactly when the bitwise AND of the event and mask registers is nonzero.
- R12: A write to the direction, open-drain, data, mask or edge-select register replaces the whole word, and a later read returns that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe |
| we_i | input | 1 | Write enable, qualified by req_i |
| addr_i | input | 5 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pad_in_i | input | 32 | Pad input levels, index = pin |
| pad_out_o | output | 32 | Pad output values, index = pin |
| pad_oe_o | output | 32 | Pad output enables, index = pin |
| irq_o | output | 1 | Interrupt line |

## Verification
Two operations can hit the same event bit on the same clock edge: a qualifying edge arriving from the synchronizer, and a write-1 clear from the register port. The bench provokes the collision by changing a pad and then issuing the clearing write in the cycle just before the third clock edge after that change. It expects the event to remain readable and the interrupt to stay high. A second clear one cycle later must then remove the bit. Random traffic produces further overlaps, and each one is judged against a cycle-level reference model that the bench builds from the requirements.

// File: rtl/egp_pkg.sv
package egp_pkg;
  localparam int unsigned NREG_SLOTS = 8;
  localparam int unsigned ADDR_W     = $clog2(NREG_SLOTS * 4);

  typedef enum logic [2:0] {
    REG_DIR = 3'd0,
    REG_ODR = 3'd1,
    REG_DAT = 3'd2,
    REG_EVT = 3'd3,
    REG_MSK = 3'd4,
    REG_ICR = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/egp_sync.sv
module egp_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) st_q[s] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/egp_event.sv
module egp_event #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] fall_only_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] ev_o
);
  logic [W-1:0] prev_q, ev_q, fall, rise, hit;

  assign fall = prev_q & ~cur_i;
  assign rise = ~prev_q & cur_i;
  assign hit  = fall | (rise & ~fall_only_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      ev_q   <= '0;
    end else begin
      prev_q <= cur_i;
      ev_q   <= (ev_q & ~clr_i) | hit;  // new edge wins over clear
    end
  end

  assign ev_o = ev_q;

  p_hit_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit != '0) |=> ((ev_q & $past(hit)) == $past(hit)));

  p_ev_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

  p_fall_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((ev_q & ~$past(ev_q)) & $past(fall_only_i & ~fall)) == '0));
endmodule

// File: rtl/edge_gpio_port.sv
module edge_gpio_port
  import egp_pkg::*;
#(
  parameter int unsigned NPIN        = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          RD_OUT_ZERO = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NPIN-1:0]      wdata_i,
  output logic [NPIN-1:0]      rdata_o,
  input  logic [NPIN-1:0]      pad_in_i,
  output logic [NPIN-1:0]      pad_out_o,
  output logic [NPIN-1:0]      pad_oe_o,
  output logic                 irq_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             wr;
  logic             unused_lsb;
  logic [NPIN-1:0]  dir_q, odr_q, dat_q, msk_q, icr_q, ev_q;
  logic [NPIN-1:0]  pad_in_r, sync_r, oe_r, out_r, dat_rd, ev_clr;

  assign idx        = addr_i[ADDR_W-1:2];
  assign unused_lsb = ^addr_i[1:0];
  assign wr         = req_i & we_i;

  // register bit NPIN-1-n belongs to pin n
  for (genvar n = 0; n < NPIN; n++) begin : g_pin
    assign pad_in_r[NPIN-1-n] = pad_in_i[n];
    assign pad_oe_o[n]        = oe_r[NPIN-1-n];
    assign pad_out_o[n]       = out_r[NPIN-1-n];
  end

  egp_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_r),
    .q_o   (sync_r)
  );

  assign ev_clr = (wr && idx == REG_EVT) ? wdata_i : '0;

  egp_event #(.W(NPIN)) u_event (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cur_i      (sync_r),
    .fall_only_i(icr_q),
    .clr_i      (ev_clr),
    .ev_o       (ev_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      odr_q <= '0;
      dat_q <= '0;
      msk_q <= '0;
      icr_q <= '0;
    end else if (wr) begin
      case (idx)
        REG_DIR: dir_q <= wdata_i;
        REG_ODR: odr_q <= wdata_i;
        REG_DAT: dat_q <= wdata_i;
        REG_MSK: msk_q <= wdata_i;
        REG_ICR: icr_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign oe_r  = dir_q & (~odr_q | ~dat_q);
  assign out_r = dat_q & ~odr_q;

  if (RD_OUT_ZERO) begin : g_rd_zero
    assign dat_rd = ~dir_q & sync_r;
  end else begin : g_rd_latch
    assign dat_rd = (dir_q & dat_q) | (~dir_q & sync_r);
  end

  always_comb begin
    case (idx)
      REG_DIR: rdata_o = dir_q;
      REG_ODR: rdata_o = odr_q;
      REG_DAT: rdata_o = dat_rd;
      REG_EVT: rdata_o = ev_q;
      REG_MSK: rdata_o = msk_q;
      REG_ICR: rdata_o = icr_q;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = |(ev_q & msk_q);

  p_irq_masked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msk_q == '0) |-> !irq_o);

  p_irq_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_q == '0) |-> !irq_o);

  p_oe_input_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((oe_r & ~dir_q) == '0));

  p_od_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((out_r & odr_q) == '0));
endmodule

// File: tb/edge_gpio_port_tb.sv
module edge_gpio_port_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, pad_in_i = '0;
  logic [31:0] rdata_o, pad_out_o, pad_oe_o, rdata_z, out_z, oe_z;
  logic        irq_o, irq_z;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  edge_gpio_port u_dut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .pad_in_i, .pad_out_o, .pad_oe_o, .irq_o);

  edge_gpio_port #(.RD_OUT_ZERO(1'b1)) u_dut_z (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o(rdata_z),
    .pad_in_i, .pad_out_o(out_z), .pad_oe_o(oe_z), .irq_o(irq_z));

  // reference model, register bit order
  logic [31:0] m_dir, m_odr, m_dat, m_ev, m_msk, m_icr, m_s1, m_s2, m_prev;

  function automatic logic [31:0] rev(input logic [31:0] v);
    for (int i = 0; i < 32; i++) rev[31-i] = v[i];
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_dir <= 0; m_odr <= 0; m_dat <= 0; m_ev <= 0; m_msk <= 0; m_icr <= 0;
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0;
    end else begin
      logic [31:0] hit, clr;
      hit = m_icr ? 32'h0 : 32'h0;
      hit = (m_prev & ~m_s2) | (~m_prev & m_s2 & ~m_icr);
      clr = (req_i && we_i && addr_i[4:2] == 3) ? wdata_i : 32'h0;
      m_ev <= (m_ev & ~clr) | hit;
      m_s1 <= rev(pad_in_i); m_s2 <= m_s1; m_prev <= m_s2;
      if (req_i && we_i)
        case (addr_i[4:2])
          0: m_dir <= wdata_i;
          1: m_odr <= wdata_i;
          2: m_dat <= wdata_i;
          4: m_msk <= wdata_i;
          5: m_icr <= wdata_i;
          default: ;
        endcase
    end
  end

  function automatic logic [31:0] exp_rd(input logic [4:0] a, input bit zero_var);
    case (a[4:2])
      0: return m_dir;
      1: return m_odr;
      2: return zero_var ? (~m_dir & m_s2) : ((m_dir & m_dat) | (~m_dir & m_s2));
      3: return m_ev;
      4: return m_msk;
      5: return m_icr;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    string t;
    case (addr_i[4:2])
      2: t = "R6 data read";
      3: t = "R8 event read";
      0, 1, 4, 5: t = "R12 readback";
      default: t = "R2 unmapped";
    endcase
    chk(t, rdata_o, exp_rd(addr_i, 0));
    chk("R7 zero-variant read", rdata_z, exp_rd(addr_i, 1));
    chk("R4 output enable", pad_oe_o, rev(m_dir & (~m_odr | ~m_dat)));
    chk("R5 pad value", pad_out_o, rev(m_dat & ~m_odr));
    chk("R11 irq", {31'b0, irq_o}, {31'b0, |(m_ev & m_msk)});
  endtask

  task automatic cyc(input bit rq, input bit w, input logic [4:0] a,
                     input logic [31:0] d, input logic [31:0] pad);
    @(negedge clk_i);
    req_i = rq; we_i = w; addr_i = a; wdata_i = d; pad_in_i = pad;
    #3;
    check_all();
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cyc(1, 1, a, d, pad_in_i);
  endtask

  task automatic rd_expect(input string tag, input logic [4:0] a, input logic [31:0] e);
    cyc(1, 0, a, 0, pad_in_i);
    chk(tag, rdata_o, e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (2) @(negedge clk_i);
    for (int a = 0; a < 8; a++) begin
      addr_i = 5'(a * 4); #1;
      chk("R1 reset reg", rdata_o, 32'h0);
    end
    chk("R1 reset oe", pad_oe_o, 32'h0);
    chk("R1 reset irq", {31'b0, irq_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R3 R4: pin 0 is bit 31
    wr(5'h00, 32'h8000_0000);
    wr(5'h08, 32'h8000_0000);
    cyc(0, 0, 5'h00, 0, 0);
    chk("R3 pin0 oe", pad_oe_o, 32'h0000_0001);
    chk("R4 pin0 out", pad_out_o, 32'h0000_0001);
    // R5 open drain
    wr(5'h04, 32'h8000_0000);
    cyc(0, 0, 5'h00, 0, 0);
    chk("R5 od release oe", pad_oe_o, 32'h0);
    wr(5'h08, 32'h0);
    cyc(0, 0, 5'h00, 0, 0);
    chk("R5 od drive low oe", pad_oe_o, 32'h0000_0001);
    chk("R5 od drive low out", pad_out_o, 32'h0);
    // R2 unmapped write ignored
    wr(5'h18, 32'hffff_ffff);
    rd_expect("R2 unmapped read", 5'h18, 32'h0);
    rd_expect("R2 dir untouched", 5'h00, 32'h8000_0000);

    // R10 collision on pin 5 (bit 26), both-edge mode, all unmasked
    wr(5'h10, 32'hffff_ffff);
    cyc(0, 0, 5'h0C, 0, 32'h0000_0020);
    cyc(0, 0, 5'h0C, 0, 32'h0000_0020);
    wr(5'h0C, 32'h0400_0000);
    rd_expect("R10 set beats clear", 5'h0C, 32'h0400_0000);
    chk("R10 irq held", {31'b0, irq_o}, 32'h1);
    wr(5'h0C, 32'h0);
    rd_expect("R9 write 0 keeps", 5'h0C, 32'h0400_0000);
    wr(5'h0C, 32'h0400_0000);
    rd_expect("R9 write 1 clears", 5'h0C, 32'h0);
    chk("R11 irq drops", {31'b0, irq_o}, 32'h0);

    // R8 falling-only on pin 7 (bit 24)
    wr(5'h14, 32'h0100_0000);
    cyc(0, 0, 5'h0C, 0, 32'h0000_00a0);
    repeat (4) cyc(0, 0, 5'h0C, 0, 32'h0000_00a0);
    rd_expect("R8 rise ignored", 5'h0C, 32'h0);
    cyc(0, 0, 5'h0C, 0, 32'h0000_0020);
    cyc(0, 0, 5'h0C, 0, 32'h0000_0020);
    cyc(0, 0, 5'h0C, 0, 32'h0000_0020);
    chk("R8 not yet set", rdata_o, 32'h0);
    cyc(0, 0, 5'h0C, 0, 32'h0000_0020);
    chk("R8 fall set", rdata_o, 32'h0100_0000);
    // R6 R7 input read of pin 7 after sync
    wr(5'h00, 32'h0);
    rd_expect("R6 input read", 5'h08, 32'h0400_0000);
    chk("R7 input read", rdata_z, 32'h0400_0000);
    wr(5'h00, 32'hffff_ffff);
    wr(5'h08, 32'h1234_5678);
    rd_expect("R6 output latch read", 5'h08, 32'h1234_5678);
    chk("R7 output reads zero", rdata_z, 32'h0);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] p;
      p = pad_in_i;
      if ($urandom % 3 == 0) p = p ^ (32'h1 << ($urandom % 32));
      if ($urandom % 16 == 0) p = $urandom;
      cyc($urandom % 2 == 0, $urandom % 2 == 0, 5'(($urandom % 8) * 4), $urandom, p);
    end
    finish_run();
  end
endmodule